// File: doc/BRIEF.md
# Branch Metric Dynamic Normalizer

This block sits in front of the add-compare-select array of a relaxed adaptive Viterbi decoder for a rate-1/2 convolutional code with hard-decision input. For each received 2-bit symbol it forms the Hamming-distance branch metrics of every butterfly in the trellis. It then shifts all of them by one common offset, chosen so that the best path metric stays close to zero. Because of this shift, the decoder never has to search all path metrics for the global best survivor.

The common offset is the smallest branch metric of the current depth plus a bias term. A floor check looks at the survivor path metrics of the previous depth, ignoring states that the pruning logic has already dropped. If any valid survivor lies strictly below a programmable floor, the bias term is zero. Otherwise it equals a programmable bias, and the path metrics then move down toward zero. The results are signed so that a biased, negative metric can be represented; clamping of path metrics at zero belongs to the downstream array. Results are registered and carry a valid strobe one cycle behind the input strobe.

Top module: `bm_normalizer`

## Requirements
- R1: The expected symbol of a branch is {parity(R & G0), parity(R & G1)}, bit 1 first, where R is the K-bit encoder register {input bit, source state}. The raw metric of the branch is the number of differing bits between rx_sym and that expected symbol (0, 1 or 2).
- R2: For butterfly j (0 ≤ j < 2^(K-2)), two metrics are produced: lane 2j for the branch from state 2j with input 0 (R = 2j), and lane 2j+1 for the branch from state 2j with input 1 (R = 2^(K-1) + 2j). Lane i occupies nbm_flat[i*ONW +: ONW].
- R3: The smallest raw metric over all lanes of the depth is subtracted from every lane.
- R4: The bias term is zero when at least one survivor state s has surv_mask[s]=1 and a path metric strictly below cfg_floor. Otherwise it is cfg_bias. A metric equal to cfg_floor does not count as below.
- R5: A state whose surv_mask bit is 0 has no effect on the floor check, whatever its path metric is.
- R6: When the floor check finds a survivor below the floor, every output lane is nonnegative and the smallest lane is exactly zero.
- R7: When the floor check finds no survivor below the floor, each lane equals raw metric − smallest raw metric − cfg_bias, as a two's-complement value of ONW bits, so the smallest lane equals −cfg_bias.
- R8: out_vld is rx_vld delayed by one clock. When rx_vld is 0, the output metrics keep their previous values.
- R9: While rst_n is low at a clock edge, out_vld and all output lanes are cleared on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_vld | input | 1 | Received symbol strobe |
| rx_sym | input | 2 | Hard-decision received symbol; bit 1 pairs with G0 |
| pm_flat | input | NS*PMW | Previous-depth path metric of each state, state s at [s*PMW +: PMW] |
| surv_mask | input | NS | 1 marks a state that survived pruning |
| cfg_floor | input | PMW | Floor for the survivor check |
| cfg_bias | input | BIASW | Bias applied when no survivor lies below the floor |
| out_vld | output | 1 | Normalized metrics strobe |
| nbm_flat | output | 2^(K-1)*ONW | Signed normalized metrics, lane i at [i*ONW +: ONW] |

## Verification
The bench sends every received symbol value through the default code (generators 7 and 5), which covers all four expected symbols; its minimum is zero, so these runs isolate the lane mapping and the Hamming distance. A second instance whose two generators are equal never expects a mixed symbol, so a mixed received symbol gives a nonzero minimum and shows that the minimum is actually subtracted. The floor check is tried with all survivors far above the floor, with one survivor exactly at the floor and one just below it, with a zero floor, and with a low metric on a masked state; the results tell the strict comparison and the mask apart. Back-to-back symbols, gaps and a maximum bias show the strobe alignment, the hold behaviour and the negative range.

// File: rtl/bmn_pkg.sv
// bmn_pkg: shared helpers for the branch metric normalizer.
// Assumes a rate-1/2 code with hard-decision 2-bit symbols.
package bmn_pkg;

    localparam int BMW = 2;  // raw Hamming metric width, values 0..2

    // Encoder output symbol for register value rv: {parity(g0&rv), parity(g1&rv)}.
    function automatic logic [1:0] exp_sym(input int unsigned g0, input int unsigned g1,
                                           input int unsigned rv);
        return {^(g0 & rv), ^(g1 & rv)};
    endfunction

    // Number of differing bits between two 2-bit symbols.
    function automatic logic [BMW-1:0] hdist(input logic [1:0] a, input logic [1:0] b);
        logic [1:0] x;
        x = a ^ b;
        return {1'b0, x[1]} + {1'b0, x[0]};
    endfunction

endpackage

// File: rtl/bmn_branch_gen.sv
// bmn_branch_gen: raw Hamming branch metrics, two per butterfly.
// Assumes G0 and G1 both have their top and bottom tap set, so that the
// branch pairs of a butterfly share metrics and two lanes cover it.
module bmn_branch_gen #(
    parameter int K  = 3,
    parameter int G0 = 7,
    parameter int G1 = 5,
    localparam int NB  = 1 << (K - 2),
    localparam int NBM = 2 * NB
) (
    input  logic [1:0]                  rx_sym,
    output logic [NBM*bmn_pkg::BMW-1:0] bm_flat
);
    import bmn_pkg::*;

    // One butterfly per iteration: lane 2j for input 0, lane 2j+1 for input 1.
    for (genvar j = 0; j < NB; j++) begin : g_bfly
        localparam int unsigned REG_A = unsigned'(j * 2);
        localparam int unsigned REG_B = unsigned'((1 << (K - 1)) + j * 2);
        localparam logic [1:0]  SYM_A = exp_sym(unsigned'(G0), unsigned'(G1), REG_A);
        localparam logic [1:0]  SYM_B = exp_sym(unsigned'(G0), unsigned'(G1), REG_B);

        assign bm_flat[(2*j)*BMW +: BMW]   = hdist(rx_sym, SYM_A);
        assign bm_flat[(2*j+1)*BMW +: BMW] = hdist(rx_sym, SYM_B);
    end

endmodule

// File: rtl/bmn_min_find.sv
// bmn_min_find: smallest of N unsigned values of W bits.
// Assumes N >= 1; the search is a plain compare chain.
module bmn_min_find #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N*W-1:0] val_flat,
    output logic [W-1:0]   min_val
);
    // Walk all values, keeping the running smallest.
    always_comb begin
        min_val = val_flat[W-1:0];
        for (int i = 1; i < N; i++) begin
            if (val_flat[i*W +: W] < min_val)
                min_val = val_flat[i*W +: W];
        end
    end

endmodule

// File: rtl/bmn_floor_check.sv
// bmn_floor_check: selects the bias term of the normalization offset.
// Outputs zero when any surviving state's metric is strictly below the
// floor, else the configured bias. Masked-out states are ignored.
module bmn_floor_check #(
    parameter int NS    = 4,
    parameter int PMW   = 8,
    parameter int BIASW = 4
) (
    input  logic [NS*PMW-1:0] pm_flat,
    input  logic [NS-1:0]     surv_mask,
    input  logic [PMW-1:0]    cfg_floor,
    input  logic [BIASW-1:0]  cfg_bias,
    output logic [BIASW-1:0]  bias_term
);
    logic [NS-1:0] below;

    // Per-state strict comparison against the floor.
    always_comb begin
        for (int s = 0; s < NS; s++)
            below[s] = pm_flat[s*PMW +: PMW] < cfg_floor;
    end

    // Bias only when no valid survivor is under the floor.
    always_comb begin
        bias_term = (|(below & surv_mask)) ? '0 : cfg_bias;
    end

endmodule

// File: rtl/bm_normalizer.sv
// bm_normalizer: per-depth dynamic normalization of branch metrics.
// Subtracts (smallest raw metric + bias term) from every lane and
// registers the signed results with a one-cycle strobe.
// Assumes one symbol per rx_vld and path metrics of the previous depth
// presented alongside it.
module bm_normalizer #(
    parameter int K     = 3,
    parameter int G0    = 7,
    parameter int G1    = 5,
    parameter int PMW   = 8,
    parameter int BIASW = 4,
    localparam int NS   = 1 << (K - 1),
    localparam int NBM  = 1 << (K - 1),
    localparam int ONW  = ((BIASW > bmn_pkg::BMW) ? BIASW : bmn_pkg::BMW) + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_vld,
    input  logic [1:0]           rx_sym,
    input  logic [NS*PMW-1:0]    pm_flat,
    input  logic [NS-1:0]        surv_mask,
    input  logic [PMW-1:0]       cfg_floor,
    input  logic [BIASW-1:0]     cfg_bias,
    output logic                 out_vld,
    output logic [NBM*ONW-1:0]   nbm_flat
);
    import bmn_pkg::*;

    logic [NBM*BMW-1:0] bm_flat;
    logic [BMW-1:0]     bm_min;
    logic [BIASW-1:0]   bias_term;
    logic [ONW-1:0]     offset;
    logic [NBM*ONW-1:0] nbm_next;

    bmn_branch_gen #(.K(K), .G0(G0), .G1(G1)) u_bgen (
        .rx_sym  (rx_sym),
        .bm_flat (bm_flat)
    );

    bmn_min_find #(.N(NBM), .W(BMW)) u_min (
        .val_flat (bm_flat),
        .min_val  (bm_min)
    );

    bmn_floor_check #(.NS(NS), .PMW(PMW), .BIASW(BIASW)) u_floor (
        .pm_flat   (pm_flat),
        .surv_mask (surv_mask),
        .cfg_floor (cfg_floor),
        .cfg_bias  (cfg_bias),
        .bias_term (bias_term)
    );

    // Common offset: smallest metric plus bias term, zero-extended.
    always_comb begin
        offset = {{(ONW-BMW){1'b0}}, bm_min} + {{(ONW-BIASW){1'b0}}, bias_term};
    end

    // Signed difference per lane.
    always_comb begin
        for (int i = 0; i < NBM; i++)
            nbm_next[i*ONW +: ONW] = {{(ONW-BMW){1'b0}}, bm_flat[i*BMW +: BMW]} - offset;
    end

    // Output register: capture on symbol strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            nbm_flat <= '0;
        end else begin
            out_vld <= rx_vld;
            if (rx_vld)
                nbm_flat <= nbm_next;
        end
    end

endmodule

// File: rtl/bm_normalizer_chk.sv
// bm_normalizer_chk: protocol and range properties of bm_normalizer,
// computed from its ports only.
module bm_normalizer_chk #(
    parameter int NS    = 4,
    parameter int NBM   = 4,
    parameter int PMW   = 8,
    parameter int BIASW = 4,
    parameter int ONW   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rx_vld,
    input logic [NS*PMW-1:0]  pm_flat,
    input logic [NS-1:0]      surv_mask,
    input logic [PMW-1:0]     cfg_floor,
    input logic [BIASW-1:0]   cfg_bias,
    input logic               out_vld,
    input logic [NBM*ONW-1:0] nbm_flat
);
    logic any_low;
    int   out_min;
    logic out_neg;

    // Observer view of the floor check from the input ports.
    always_comb begin
        any_low = 1'b0;
        for (int s = 0; s < NS; s++)
            if (surv_mask[s] && (pm_flat[s*PMW +: PMW] < cfg_floor))
                any_low = 1'b1;
    end

    // Smallest output lane and presence of any negative lane.
    always_comb begin
        out_min = int'($signed(nbm_flat[ONW-1:0]));
        out_neg = 1'b0;
        for (int i = 0; i < NBM; i++) begin
            if (int'($signed(nbm_flat[i*ONW +: ONW])) < out_min)
                out_min = int'($signed(nbm_flat[i*ONW +: ONW]));
            if (nbm_flat[i*ONW + ONW - 1])
                out_neg = 1'b1;
        end
    end

    p_vld_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |=> out_vld);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_vld |=> (!out_vld && $stable(nbm_flat)));

    p_min_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && any_low) |=> (out_min == 0));

    p_nonneg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && any_low) |=> !out_neg);

    p_bias_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && !any_low) |=> (out_min == -int'($past(cfg_bias))));

    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && (nbm_flat == '0)));

endmodule

bind bm_normalizer bm_normalizer_chk #(
    .NS(NS), .NBM(NBM), .PMW(PMW), .BIASW(BIASW), .ONW(ONW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .pm_flat(pm_flat),
    .surv_mask(surv_mask), .cfg_floor(cfg_floor), .cfg_bias(cfg_bias),
    .out_vld(out_vld), .nbm_flat(nbm_flat)
);

// File: tb/bm_normalizer_bench.sv
// Scoreboard bench: the driver pushes expected lanes, the monitor pops
// and compares them when out_vld appears.
module bm_normalizer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PMW   = 8;
    localparam int BIASW = 4;
    localparam int ONW   = 6;
    localparam int NL    = 4;
    localparam int OW    = NL * ONW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           rx_vld = 1'b0;
    logic [1:0]     rx_sym = '0;
    logic [4*PMW-1:0] pm_flat = '0;
    logic [3:0]     surv_mask = '0;
    logic [PMW-1:0] cfg_floor = '0;
    logic [BIASW-1:0] cfg_bias = '0;
    logic           out_vld_a, out_vld_b;
    logic [OW-1:0]  nbm_a, nbm_b;

    int n_cmp = 0;
    int n_bad = 0;
    logic [OW-1:0] q_a[$];
    logic [OW-1:0] q_b[$];
    string         q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bm_normalizer u_bm_normalizer (
        .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_sym(rx_sym),
        .pm_flat(pm_flat), .surv_mask(surv_mask), .cfg_floor(cfg_floor),
        .cfg_bias(cfg_bias), .out_vld(out_vld_a), .nbm_flat(nbm_a)
    );

    // Second instance with equal generators: only symbols 00 and 11 expected.
    bm_normalizer #(.G0(7), .G1(7)) u_bm_normalizer_rep (
        .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_sym(rx_sym),
        .pm_flat(pm_flat), .surv_mask(surv_mask), .cfg_floor(cfg_floor),
        .cfg_bias(cfg_bias), .out_vld(out_vld_b), .nbm_flat(nbm_b)
    );

    // Expected lanes from the requirements (K = 3).
    function automatic logic [OW-1:0] model(int g0, int g1, logic [1:0] sym,
                                            logic [4*PMW-1:0] pm, logic [3:0] msk,
                                            int flr, int bias);
        int bm[NL];
        int mn;
        int sub;
        logic low;
        logic [OW-1:0] o;
        logic [31:0] tmp;
        for (int j = 0; j < 2; j++) begin
            for (int u = 0; u < 2; u++) begin
                int rv;
                logic [1:0] e;
                rv = (u << 2) | (j << 1);
                e = {^(g0 & rv), ^(g1 & rv)};
                bm[2*j+u] = $countones(e ^ sym);
            end
        end
        mn = bm[0];
        for (int i = 1; i < NL; i++) if (bm[i] < mn) mn = bm[i];
        low = 1'b0;
        for (int s = 0; s < 4; s++)
            if (msk[s] && (int'(pm[s*PMW +: PMW]) < flr)) low = 1'b1;
        sub = mn + (low ? 0 : bias);
        for (int i = 0; i < NL; i++) begin
            tmp = 32'(bm[i] - sub);
            o[i*ONW +: ONW] = tmp[ONW-1:0];
        end
        return o;
    endfunction

    function automatic logic [4*PMW-1:0] pms(int p0, int p1, int p2, int p3);
        return {8'(p3), 8'(p2), 8'(p1), 8'(p0)};
    endfunction

    task automatic check(string tag, logic [OW-1:0] act, logic [OW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one symbol per call, expected values pushed at drive time.
    task automatic drive(string tag, logic [1:0] sym, logic [4*PMW-1:0] pm,
                         logic [3:0] msk, int flr, int bias);
        @(negedge clk);
        rx_vld = 1'b1; rx_sym = sym; pm_flat = pm; surv_mask = msk;
        cfg_floor = PMW'(flr); cfg_bias = BIASW'(bias);
        q_a.push_back(model(7, 5, sym, pm, msk, flr, bias));
        q_b.push_back(model(7, 7, sym, pm, msk, flr, bias));
        q_tag.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_vld = 1'b0;
            rx_sym = ~rx_sym;
            pm_flat = '0;
            surv_mask = 4'hf;
        end
    endtask

    // Monitor: compare both instances whenever a result strobe is seen.
    always @(negedge clk) begin
        if (rst_n && (out_vld_a || out_vld_b)) begin
            if (q_a.size() == 0 || !out_vld_a || !out_vld_b) begin
                n_cmp++; n_bad++;
                $display("FAIL R8: unexpected strobe actual %b%b expected 00", out_vld_a, out_vld_b);
            end else begin
                string t;
                t = q_tag.pop_front();
                check({t, " lanes"}, nbm_a, q_a.pop_front());
                check({t, " rep lanes"}, nbm_b, q_b.pop_front());
            end
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [OW-1:0] held;
        repeat (3) @(negedge clk);
        // R9: cleared after reset
        check("R9 reset lanes", nbm_a, '0);
        check("R9 reset strobe", {23'd0, out_vld_a}, '0);
        rst_n = 1'b1;

        // R1 R2 R6: floor passes, all symbols on the default code
        drive("R1 R2 R6 sym00", 2'b00, pms(0, 0, 0, 0), 4'hf, 4, 3);
        drive("R1 R2 R6 sym11", 2'b11, pms(0, 0, 0, 0), 4'hf, 4, 3);
        drive("R1 R2 R3 sym01", 2'b01, pms(1, 9, 9, 9), 4'hf, 4, 3);
        drive("R1 R2 sym10", 2'b10, pms(9, 9, 9, 2), 4'hf, 4, 3);
        // R7: no survivor under the floor
        drive("R7 all high", 2'b10, pms(50, 60, 70, 80), 4'hf, 4, 3);
        // R4 boundary: equal to floor is not below
        drive("R4 at floor", 2'b00, pms(50, 50, 4, 50), 4'hf, 4, 3);
        drive("R4 under floor", 2'b00, pms(50, 50, 3, 50), 4'hf, 4, 3);
        drive("R4 zero floor", 2'b11, pms(0, 0, 0, 0), 4'hf, 0, 5);
        // R5: masked low metric ignored, unmasked low metric counts
        drive("R5 masked low", 2'b01, pms(0, 50, 50, 50), 4'b1110, 4, 2);
        drive("R5 unmasked low", 2'b01, pms(0, 50, 50, 50), 4'b0001, 4, 2);
        // R3: equal generators give nonzero minimum for mixed symbols
        drive("R3 mixed pass", 2'b10, pms(0, 0, 0, 0), 4'hf, 4, 7);
        drive("R3 R7 mixed bias", 2'b01, pms(40, 40, 40, 40), 4'hf, 4, 2);
        // R7: maximum bias
        drive("R7 max bias", 2'b11, pms(99, 99, 99, 99), 4'hf, 1, 15);
        idle(1);
        // R8: lanes hold over idle cycles with changing inputs
        @(negedge clk);
        held = nbm_a;
        idle(3);
        check("R8 hold", nbm_a, held);
        check("R8 strobe low", {23'd0, out_vld_a}, '0);
        drive("R8 after gap", 2'b10, pms(0, 0, 0, 0), 4'hf, 4, 3);
        idle(1);
        drive("R8 single", 2'b01, pms(90, 0, 0, 0), 4'b0001, 4, 6);
        idle(3);
        // R9: reset mid-run clears the lanes
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 second reset", nbm_a, '0);
        rst_n = 1'b1;
        idle(2);
        n_cmp++;
        if (q_a.size() != 0) begin
            n_bad++;
            $display("FAIL R8: pending actual %0d expected 0", q_a.size());
        end
        finish_run();
    end

endmodule